// File: doc/BRIEF.md
# Indexed Control Register Slave on a Two-Wire Bus

This block is a two-wire serial slave that holds a small bank of 8-bit control registers for a clock generator. A host reaches the bank through indexed transfers. Every transfer names a starting register offset and then carries a byte count. On a write, the count says how many data bytes follow. On a read, the slave sends the count itself before the data. The clock control logic sees every register at all times through one flat parallel output.

The bus lines are sampled by the system clock through two-stage synchronizers. The slave detects start, repeated start and stop, matches the address byte, and acknowledges or rejects each byte. It steps the register offset after each byte. SDA is open-drain: the block only ever pulls the line low, through `sda_oe`. Two register slots are not storage. Three strap bits read back the live `strap_i` pins, and one slot reads back the `id_i` byte. Writes to those bits change nothing that can be seen.

Top module: `smb_regbank`

## Requirements
- R1: After reset, offsets 0 to 2 hold FFh, offsets 3 to 5 hold 00h, offset 8 (the read byte count) holds 08h, and every other storage register holds 00h.
- R2: The slave acknowledges only the address bytes D2h (write) and D3h (read), and it starts pulling SDA low only while SCL is low. After any other address it does not acknowledge that byte. It then stays off the bus until the next start.
- R3: A write transfer sends D2h, an offset, a count N and then N data bytes. The slave acknowledges all of these. Data byte k is stored at offset+k, where the offset is 8 bits wide and wraps from FFh to 00h.
- R4: A count byte of 00h is not acknowledged and nothing is stored. Any data byte after the N-th is not acknowledged and is discarded.
- R5: A read transfer sends D2h, then the offset, then a repeated start, then D3h. The slave then sends the value of offset 8 as a count byte, followed by register bytes from the offset upward. It keeps sending for as long as the master acknowledges.
- R6: A master nack, or a stop received at any point, makes the slave release SDA. It then stays silent until the next start. The master may stop a read after any bit that the slave sends as 1.
- R7: Bits 2:0 of offset 6 always read as `strap_i`, and offset 7 always reads as `id_i`. Writes to these bits are acknowledged and have no effect. Bits 7:3 of offset 6 are ordinary storage.
- R8: Offsets at or above NREG (16) are acknowledged on write, but the data is discarded. They read as 00h.
- R9: Register k appears on `regs_o[8k+7:8k]` with the same value that a bus read of offset k returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_o | output | 1 | Data driven when enabled (always 0) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| strap_i | input | 3 | Latched strap values, read-only at offset 6 |
| id_i | input | 8 | Identification byte, read-only at offset 7 |
| regs_o | output | 128 | All registers, offset k at bits 8k+7:8k |

## Verification
There are two main ways an internal state can go wrong. A stale offset or count shows up as a wrong value at the next quiet moment on `regs_o`, because the bench compares the whole bank against its own model on every idle clock. A slip in the bit or acknowledge sequencing shows up within one bit time: an acknowledge appears where none was expected, or `sda_oe` stays asserted across a stop. The count byte, wrapped offsets, the read-only slots and an early stop are each driven over the bus, and each is read back through the bus.

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int          NREG      = 16,
  parameter logic [7:0]  WR_ADDR   = 8'hD2,
  parameter logic [7:0]  RD_ADDR   = 8'hD3,
  parameter int          N_OE      = 3,
  parameter int          STRAP_IDX = 6,
  parameter int          STRAP_W   = 3,
  parameter int          ID_IDX    = 7,
  parameter int          CNT_IDX   = 8,
  parameter logic [7:0]  CNT_INIT  = 8'd8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_o,
  output logic                sda_oe,
  input  logic [STRAP_W-1:0]  strap_i,
  input  logic [7:0]          id_i,
  output logic [NREG*8-1:0]   regs_o
);
  localparam int         IW    = $clog2(NREG);
  localparam logic [8:0] NREG9 = 9'(NREG);

  typedef enum logic [2:0] {P_IDLE, P_RX, P_ACK, P_TX, P_MACK} phase_t;

  logic [2:0] scl_s, sda_s;
  phase_t     phase;
  logic [1:0] step;
  logic       rd;
  logic [3:0] bcnt;
  logic [7:0] sh, ofs, left;
  logic [7:0] rf [NREG];
  logic [7:0] rv [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  wire scl_r    = scl_s[1];
  wire sda_r    = sda_s[1];
  wire scl_rise = scl_r & ~scl_s[2];
  wire scl_fall = ~scl_r & scl_s[2];
  wire start_d  = scl_r & scl_s[2] & sda_s[2] & ~sda_r;
  wire stop_d   = scl_r & scl_s[2] & ~sda_s[2] & sda_r;

  wire [7:0] rx_byte   = {sh[6:0], sda_r};
  wire       byte_done = (phase == P_RX) && scl_rise && (bcnt == 4'd7);
  wire       in_rng    = {1'b0, ofs} < NREG9;
  wire       wr_en     = byte_done && step == 2'd3 && left != 8'd0 && in_rng;
  wire [7:0] tx_byte   = (step == 2'd2) ? rf[CNT_IDX] : (in_rng ? rv[ofs[IW-1:0]] : 8'h00);

  assign sda_o = 1'b0;

  function automatic logic [7:0] init_val(int i);
    if (i < N_OE) return 8'hFF;
    if (i == CNT_IDX) return CNT_INIT;
    return 8'h00;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= init_val(i);
    end else if (wr_en) begin
      rf[ofs[IW-1:0]] <= rx_byte;
    end

  always_comb begin
    for (int i = 0; i < NREG; i++) rv[i] = rf[i];
    rv[STRAP_IDX][STRAP_W-1:0] = strap_i;
    rv[ID_IDX] = id_i;
    for (int i = 0; i < NREG; i++) regs_o[i*8 +: 8] = rv[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= P_IDLE; step <= 2'd0; rd <= 1'b0; bcnt <= 4'd0;
      sh <= 8'h00; ofs <= 8'h00; left <= 8'h00; sda_oe <= 1'b0;
    end else if (start_d) begin
      phase <= P_RX; step <= 2'd0; bcnt <= 4'd0; sda_oe <= 1'b0;
    end else if (stop_d) begin
      phase <= P_IDLE; sda_oe <= 1'b0;
    end else begin
      case (phase)
        P_RX: if (scl_rise) begin
          sh   <= rx_byte;
          bcnt <= bcnt + 4'd1;
          if (bcnt == 4'd7) begin
            phase <= P_ACK;
            case (step)
              2'd0: if (rx_byte == WR_ADDR) begin rd <= 1'b0; step <= 2'd1; end
                    else if (rx_byte == RD_ADDR) begin rd <= 1'b1; step <= 2'd2; end
                    else phase <= P_IDLE;
              2'd1: begin ofs <= rx_byte; step <= 2'd2; end
              2'd2: if (rx_byte != 8'd0) begin left <= rx_byte; step <= 2'd3; end
                    else phase <= P_IDLE;
              default: if (left != 8'd0) begin left <= left - 8'd1; ofs <= ofs + 8'd1; end
                       else phase <= P_IDLE;
            endcase
          end
        end
        P_ACK: if (scl_fall) begin
          if (!sda_oe) sda_oe <= 1'b1;
          else begin
            bcnt <= 4'd0;
            if (rd) begin
              phase <= P_TX; sh <= tx_byte; sda_oe <= ~tx_byte[7];
            end else begin
              phase <= P_RX; sda_oe <= 1'b0;
            end
          end
        end
        P_TX: begin
          if (scl_rise) bcnt <= bcnt + 4'd1;
          if (scl_fall) begin
            if (bcnt == 4'd8) begin
              sda_oe <= 1'b0; phase <= P_MACK;
            end else begin
              sh <= {sh[6:0], sh[7]}; sda_oe <= ~sh[6];
            end
          end
        end
        P_MACK: begin
          if (scl_rise) begin
            if (sda_r) phase <= P_IDLE;
            else if (step == 2'd2) step <= 2'd3;
            else ofs <= ofs + 8'd1;
          end
          if (scl_fall) begin
            bcnt <= 4'd0; phase <= P_TX; sh <= tx_byte; sda_oe <= ~tx_byte[7];
          end
        end
        default: ;
      endcase
    end

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_r); // R2
  AST_BAD_ADDR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && step == 2'd0 && rx_byte != WR_ADDR && rx_byte != RD_ADDR |=> phase == P_IDLE && !sda_oe); // R2
  AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> phase == P_ACK); // R3
  AST_ZERO_COUNT_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done && step == 2'd2 && !rd && rx_byte == 8'd0 |=> phase == P_IDLE); // R4
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) stop_d |=> !sda_oe && phase == P_IDLE); // R6
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n) phase == P_IDLE |-> !sda_oe); // R6
endmodule

// File: tb/smb_regbank_tb.sv
`timescale 1ns/1ps
module smb_regbank_tb;
  localparam int H = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] ID = 8'h4C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_o, sda_oe;
  logic [127:0] regs_o;
  wire sda_line = m_sda & ~sda_oe;

  int checks = 0, fails = 0;
  bit quiet = 1'b0, done = 1'b0;
  logic [7:0] m [16];

  always #2.5 clk = ~clk;

  smb_regbank u_dut (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe), .strap_i(STRAP), .id_i(ID), .regs_o(regs_o));

  function automatic logic [7:0] view(int a);
    a = a & 255;
    if (a >= 16) return 8'h00;
    if (a == 6) return {m[6][7:3], STRAP};
    if (a == 7) return ID;
    return m[a];
  endfunction

  function automatic void mwrite(int a, logic [7:0] d);
    a = a & 255;
    if (a < 16) m[a] = d;
  endfunction

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // R9: whole bank compared to the model on every idle clock
  always @(negedge clk) if (quiet && rst_n && !done) begin
    logic [127:0] e;
    for (int i = 0; i < 16; i++) e[i*8 +: 8] = view(i);
    checks++;
    if (regs_o !== e) begin
      fails++;
      if (fails < 10) $display("FAIL R9 actual=%h expected=%h", regs_o, e);
    end
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start; m_sda = 1; m_scl = 1; tick(H); m_sda = 0; tick(H); m_scl = 0; tick(H); endtask
  task automatic bus_rstart; m_sda = 1; tick(H); m_scl = 1; tick(H); m_sda = 0; tick(H); m_scl = 0; tick(H); endtask
  task automatic bus_stop; m_sda = 0; tick(H); m_scl = 1; tick(H); m_sda = 1; tick(H); endtask
  task automatic put_bit(logic b); m_sda = b; tick(H); m_scl = 1; tick(H); m_scl = 0; tick(H); endtask
  task automatic get_bit(output logic b);
    m_sda = 1; tick(H); m_scl = 1; tick(H/2); b = sda_line; tick(H/2); m_scl = 0; tick(H);
  endtask
  task automatic put_byte(logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b); ack = ~b;
  endtask
  task automatic get_byte(output logic [7:0] d, input logic last);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(last);
  endtask
  task automatic idle; tick(10); quiet = 1'b1; tick(40); endtask

  task automatic wr_block(logic [7:0] ofs, logic [7:0] n, int nd,
                          logic [7:0] d0, logic [7:0] d1, logic [7:0] d2, string req);
    logic a; logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    quiet = 1'b0;
    bus_start;
    put_byte(8'hD2, a); chk(a, "R2 write address ack", {7'd0, a}, 8'h01);
    put_byte(ofs, a);   chk(a, "R3 offset ack", {7'd0, a}, 8'h01);
    put_byte(n, a);     chk(a == (n != 0), "R4 count ack", {7'd0, a}, {7'd0, n != 0});
    for (int i = 0; i < nd; i++) begin
      put_byte(d[i], a);
      chk(a == (i < n), {req, " data ack"}, {7'd0, a}, {7'd0, i < n});
      if (i < n) mwrite(ofs + i, d[i]);
    end
    bus_stop;
    chk(!sda_oe, "R6 released after stop", {7'd0, sda_oe}, 8'h00);
    idle;
  endtask

  task automatic rd_block(logic [7:0] ofs, int n, string req);
    logic a; logic [7:0] d;
    quiet = 1'b0;
    bus_start;
    put_byte(8'hD2, a); chk(a, "R2 address ack", {7'd0, a}, 8'h01);
    put_byte(ofs, a);   chk(a, "R5 offset ack", {7'd0, a}, 8'h01);
    bus_rstart;
    put_byte(8'hD3, a); chk(a, "R2 read address ack", {7'd0, a}, 8'h01);
    get_byte(d, 1'b0);  chk(d == view(8), "R5 count byte", d, view(8));
    for (int k = 0; k < n; k++) begin
      get_byte(d, k == n - 1);
      chk(d == view(ofs + k), req, d, view(ofs + k));
    end
    tick(4);
    chk(!sda_oe, "R6 released after nack", {7'd0, sda_oe}, 8'h00);
    bus_stop;
    idle;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1; fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic a, b; logic [7:0] d;
    for (int i = 0; i < 16; i++) m[i] = (i < 3) ? 8'hFF : (i == 8) ? 8'h08 : 8'h00;
    tick(5); rst_n = 1'b1; tick(5);
    chk(regs_o[7:0] == 8'hFF, "R1 reset offset 0", regs_o[7:0], 8'hFF);
    chk(regs_o[31:24] == 8'h00, "R1 reset offset 3", regs_o[31:24], 8'h00);
    chk(regs_o[71:64] == 8'h08, "R1 reset count", regs_o[71:64], 8'h08);
    idle;
    rd_block(8'h00, 9, "R1 reset value read");
    wr_block(8'h09, 8'd3, 3, 8'hA1, 8'hB2, 8'hC3, "R3 block write");
    rd_block(8'h09, 3, "R3 readback");
    wr_block(8'h00, 8'd1, 2, 8'h5A, 8'h77, 8'h00, "R4 extra byte");
    wr_block(8'h03, 8'd0, 1, 8'hAA, 8'h00, 8'h00, "R4 zero count");
    rd_block(8'h00, 4, "R4 readback");
    wr_block(8'h06, 8'd2, 2, 8'hFF, 8'h00, 8'h00, "R7 read-only write");
    rd_block(8'h06, 2, "R7 readback");
    wr_block(8'h0F, 8'd3, 3, 8'hE1, 8'hE2, 8'hE3, "R8 past end");
    wr_block(8'hFF, 8'd2, 2, 8'h11, 8'h22, 8'h00, "R3 offset wrap");
    wr_block(8'h08, 8'd1, 1, 8'h03, 8'h00, 8'h00, "R5 count write");
    rd_block(8'h0E, 4, "R8 read past end");
    rd_block(8'hFF, 2, "R8 read wrap");
    rd_block(8'h0A, 1, "R5 single byte read");

    // R2: foreign address, slave stays silent
    quiet = 1'b0;
    bus_start;
    put_byte(8'hA0, a); chk(!a, "R2 foreign address nack", {7'd0, a}, 8'h00);
    put_byte(8'h00, a); chk(!a, "R2 silent until start", {7'd0, a}, 8'h00);
    bus_stop; idle;

    // R6: stop in the middle of a read byte
    wr_block(8'h0C, 8'd1, 1, 8'hC0, 8'h00, 8'h00, "R3 setup");
    quiet = 1'b0;
    bus_start;
    put_byte(8'hD2, a); put_byte(8'h0C, a);
    bus_rstart;
    put_byte(8'hD3, a); chk(a, "R2 read address ack", {7'd0, a}, 8'h01);
    get_byte(d, 1'b0);  chk(d == view(8), "R5 count byte", d, view(8));
    get_bit(b);         chk(b, "R5 first data bit", {7'd0, b}, 8'h01);
    bus_stop;
    chk(!sda_oe, "R6 released after early stop", {7'd0, sda_oe}, 8'h00);
    idle;
    rd_block(8'h0C, 1, "R6 usable after early stop");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule